// File: doc/BRIEF.md
# Eight-bit ALU with condition flags

This block is the arithmetic and logic unit of a small communications controller. Each cycle in which `op_valid` is high, it takes two byte operands, an operation code and a shift amount. At the next clock edge it registers a byte result, a write-enable for that result and an updated four-bit condition register. The with-carry forms of add and subtract take their carry or borrow input from the C flag held in that register. Compare and test update only the flags. Logic operations and complement change only N and Z. The shift and rotate operations take their carry-out from the bit position that the shift amount selects.

The block also holds the condition multiplexer that conditional branches use. A three-bit select picks one of the four flags or one of four external status inputs. The selected value is presented combinationally on `cond_true`.

The house style centres each block on a state machine. This block has no sequencing of its own, so it keeps only the naming and reset style, one register process and one output process. Its only state is the registered result, the write-enable and the flag register. That state holds while no operation is presented.

Top module: `alu8_core`

## Requirements
- R1: After reset, `result` is 0x00, `result_we` is 0 and `flags` is 0x0. The flag bit positions are Z=bit 0, C=bit 1, V=bit 2 and N=bit 3.
- R2: Op codes 0 (ADD) and 1 (ADC) write A+B+cin. The cin is 0 for ADD and the current C flag for ADC. C is set when the unsigned sum is at least 0x100. V is set when A and B have the same sign and the result sign differs from it.
- R3: Op codes 2 (SUB) and 3 (SBC) write A-B-bin. The bin is 0 for SUB and the current C flag for SBC. C is set when A < B+bin. V is set when the signs of A and B differ and the result sign differs from the sign of A.
- R4: Op code 4 (CMP, flags as SUB with bin=0) and op code 8 (TEST, flags as AND) update the flags but leave `result_we` at 0 and `result` unchanged.
- R5: Op codes 5 (AND), 6 (OR), 7 (XOR) and 9 (NOT, the bitwise inverse of A) write their result and update N and Z only. C and V keep their values.
- R6: Every operation recomputes Z (set when the result is zero) and N (a copy of result bit 7). Z and N are never set together.
- R7: Op code 10 (SHR) writes A>>n and op code 11 (SHL) writes A<<n, where n = `shift_amt`. For SHR, C is bit n-1 of A. For SHL, C is bit 8-n of A. In both, C is 0 when n=0. V is unchanged.
- R8: Op code 12 (ROR) writes A rotated right by n places. C is bit n-1 of A, and 0 when n=0. V is unchanged.
- R9: `cond_true` selects by `cond_sel`: 0=Z, 1=C, 2=V, 3=N from the current flags, and 4..7 = `status_in[0..3]` (receiver active, receiver error, data available, transmit FIFO full).
- R10: With `op_valid` low, or with a reserved op code (13..15), the next cycle has `result_we`=0, and `result` and `flags` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_code | input | 4 | Operation code (see R2..R8) |
| opnd_a | input | 8 | Operand A |
| opnd_b | input | 8 | Operand B |
| shift_amt | input | 3 | Shift or rotate amount, 0..7 |
| cond_sel | input | 3 | Branch condition select |
| status_in | input | 4 | External status bits for condition codes 4..7 |
| result | output | 8 | Registered result |
| result_we | output | 1 | Result write-enable, one cycle per writing operation |
| flags | output | 4 | Condition register {N,V,C,Z} |
| cond_true | output | 1 | Selected branch condition |

## Verification
The assertions check four things on every cycle. Idle and reserved cycles hold the state. Compare and test never raise the write-enable. Logic operations keep C and V. Z and N are consistent with each written result and never set together. Only the bench's reference model can show the arithmetic values. It checks the carry and borrow at the 0xFF/0x00 edges, signed overflow at 0x7F/0x80, carry chaining through ADC and SBC, the carry bit for each shift amount including zero, and every condition-select code. The model runs over directed cases and a long pseudo-random operation stream.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int FLAG_W = 4;
    localparam int FLG_Z  = 0;
    localparam int FLG_C  = 1;
    localparam int FLG_V  = 2;
    localparam int FLG_N  = 3;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_TST = 4'd8,
        OP_NOT = 4'd9,
        OP_SHR = 4'd10,
        OP_SHL = 4'd11,
        OP_ROR = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_RIGHT = 2'd0,
        SH_LEFT  = 2'd1,
        SH_ROT   = 2'd2
    } shift_mode_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              c_eff;
    logic              c_out;

    always_comb begin
        b_eff          = do_sub ? ~b : b;
        c_eff          = do_sub ? ~cin : cin;
        {c_out, sum}   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
        carry          = do_sub ? ~c_out : c_out;
        ovf            = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] d,
    input  logic [SH_W-1:0]   amt,
    input  shift_mode_e       mode,
    output logic [DATA_W-1:0] q,
    output logic              carry
);
    logic [2*DATA_W-1:0] dd;
    logic [DATA_W-1:0]   rot_tab [DATA_W];
    logic [DATA_W:0]     right_ext;
    logic [DATA_W:0]     left_ext;

    assign dd = {d, d};

    for (genvar k = 0; k < DATA_W; k++) begin : g_rot
        assign rot_tab[k] = dd[k +: DATA_W];
    end

    always_comb begin
        right_ext = {d, 1'b0} >> amt;
        left_ext  = {1'b0, d} << amt;
        unique case (mode)
            SH_RIGHT: begin
                q     = d >> amt;
                carry = right_ext[0];
            end
            SH_LEFT: begin
                q     = d << amt;
                carry = left_ext[DATA_W];
            end
            default: begin
                q     = rot_tab[amt];
                carry = right_ext[0];
            end
        endcase
    end

endmodule

// File: rtl/alu8_cond.sv
module alu8_cond
    import alu8_pkg::*;
#(
    parameter int N_EXT  = 4,
    localparam int N_SRC = FLAG_W + N_EXT,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [N_EXT-1:0]  status_in,
    input  logic [SEL_W-1:0]  sel,
    output logic              cond
);
    logic [N_SRC-1:0] src;

    assign src  = {status_in, flags};
    assign cond = src[sel];

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_EXT  = 4,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int SEL_W = $clog2(FLAG_W + N_EXT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [SH_W-1:0]   shift_amt,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic [N_EXT-1:0]  status_in,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic [FLAG_W-1:0] flags,
    output logic              cond_true
);
    localparam int MSB = DATA_W - 1;

    alu_op_e            op;
    logic [DATA_W-1:0]  res_q, res_d;
    logic               we_q, we_d;
    logic [FLAG_W-1:0]  flags_q, flags_d;

    logic               ar_sub, ar_cin, ar_c, ar_v;
    logic [DATA_W-1:0]  ar_sum;
    shift_mode_e        sh_mode;
    logic [DATA_W-1:0]  sh_q;
    logic               sh_c;

    assign op = alu_op_e'(op_code);

    // Arithmetic path: borrow-as-carry on subtract, carry flag feeds the with-carry forms
    assign ar_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    assign ar_cin = ((op == OP_ADC) || (op == OP_SBC)) ? flags_q[FLG_C] : 1'b0;

    alu8_arith #(.DATA_W(DATA_W)) i_arith (
        .a      (opnd_a),
        .b      (opnd_b),
        .cin    (ar_cin),
        .do_sub (ar_sub),
        .sum    (ar_sum),
        .carry  (ar_c),
        .ovf    (ar_v)
    );

    always_comb begin
        unique case (op)
            OP_SHL:  sh_mode = SH_LEFT;
            OP_ROR:  sh_mode = SH_ROT;
            default: sh_mode = SH_RIGHT;
        endcase
    end

    alu8_shift #(.DATA_W(DATA_W)) i_shift (
        .d     (opnd_a),
        .amt   (shift_amt),
        .mode  (sh_mode),
        .q     (sh_q),
        .carry (sh_c)
    );

    alu8_cond #(.N_EXT(N_EXT)) i_cond (
        .flags     (flags_q),
        .status_in (status_in),
        .sel       (cond_sel),
        .cond      (cond_true)
    );

    // Next-state process
    always_comb begin
        logic [DATA_W-1:0] val;
        logic              wr, upd_nz;
        val     = '0;
        wr      = 1'b0;
        upd_nz  = 1'b0;
        flags_d = flags_q;
        if (op_valid) begin
            unique case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                    val            = ar_sum;
                    wr             = (op != OP_CMP);
                    upd_nz         = 1'b1;
                    flags_d[FLG_C] = ar_c;
                    flags_d[FLG_V] = ar_v;
                end
                OP_AND, OP_TST: begin
                    val    = opnd_a & opnd_b;
                    wr     = (op == OP_AND);
                    upd_nz = 1'b1;
                end
                OP_OR: begin
                    val    = opnd_a | opnd_b;
                    wr     = 1'b1;
                    upd_nz = 1'b1;
                end
                OP_XOR: begin
                    val    = opnd_a ^ opnd_b;
                    wr     = 1'b1;
                    upd_nz = 1'b1;
                end
                OP_NOT: begin
                    val    = ~opnd_a;
                    wr     = 1'b1;
                    upd_nz = 1'b1;
                end
                OP_SHR, OP_SHL, OP_ROR: begin
                    val            = sh_q;
                    wr             = 1'b1;
                    upd_nz         = 1'b1;
                    flags_d[FLG_C] = sh_c;
                end
                default: begin
                    val    = '0;
                    wr     = 1'b0;
                    upd_nz = 1'b0;
                end
            endcase
        end
        if (upd_nz) begin
            flags_d[FLG_Z] = (val == '0);
            flags_d[FLG_N] = (val != '0) && val[MSB];
        end
        res_d = wr ? val : res_q;
        we_d  = wr;
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            we_q    <= 1'b0;
            flags_q <= '0;
        end else begin
            res_q   <= res_d;
            we_q    <= we_d;
            flags_q <= flags_d;
        end
    end

    assign result    = res_q;
    assign result_we = we_q;
    assign flags     = flags_q;

    // R10: idle and reserved cycles hold the state
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code > 4'd12) |=> (!result_we && $stable(flags) && $stable(result)));

    // R4: compare and test never write
    a_r4_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd4 || op_code == 4'd8)) |=> (!result_we && $stable(result)));

    // R5: logic ops keep C and V
    a_r5_keep_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd5 && op_code <= 4'd9) |=>
        (flags[FLG_C] == $past(flags[FLG_C]) && flags[FLG_V] == $past(flags[FLG_V])));

    // R6: Z tracks a written result
    a_r6_z_match: assert property (@(posedge clk) disable iff (!rst_n)
        result_we |-> (flags[FLG_Z] == (result == '0)));

    // R6: Z and N exclusive
    a_r6_zn_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags[FLG_Z] && flags[FLG_N]));

    // R7/R8: V untouched by shifts and rotates
    a_r7_shift_keep_v: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd10 && op_code <= 4'd12) |=> $stable(flags[FLG_V]));

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic [2:0] shift_amt = '0, cond_sel = '0;
    logic [3:0] status_in = '0;
    logic [7:0] result;
    logic       result_we;
    logic [3:0] flags;
    logic       cond_true;

    int checks = 0;
    int fails  = 0;
    int m_res = 0, m_we = 0, m_flags = 0;

    always #2 clk = ~clk;

    alu8_core i_alu8_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_amt(shift_amt),
        .cond_sel(cond_sel), .status_in(status_in),
        .result(result), .result_we(result_we), .flags(flags), .cond_true(cond_true)
    );

    // Behavioural reference model: Z=bit0 C=bit1 V=bit2 N=bit3
    task automatic model_update(input int v, input int op, input int a, input int b, input int n);
        int r, c, ov, wr, nz, cin;
        c  = (m_flags >> 1) & 1;
        ov = (m_flags >> 2) & 1;
        r = 0; wr = 0; nz = 0;
        cin = (op == 1 || op == 3) ? c : 0;
        if (v != 0) begin
            case (op)
                0, 1: begin
                    r = a + b + cin;
                    c = (r >= 256) ? 1 : 0;
                    r = r % 256;
                    ov = (((a ^ r) & (b ^ r) & 128) != 0) ? 1 : 0;
                    wr = 1; nz = 1;
                end
                2, 3, 4: begin
                    r = (a - b - cin + 512) % 256;
                    c = (a < b + cin) ? 1 : 0;
                    ov = (((a ^ b) & (a ^ r) & 128) != 0) ? 1 : 0;
                    wr = (op != 4) ? 1 : 0; nz = 1;
                end
                5: begin r = a & b; wr = 1; nz = 1; end
                6: begin r = a | b; wr = 1; nz = 1; end
                7: begin r = a ^ b; wr = 1; nz = 1; end
                8: begin r = a & b; wr = 0; nz = 1; end
                9: begin r = 255 - a; wr = 1; nz = 1; end
                10: begin r = a >> n; c = (n == 0) ? 0 : (a >> (n - 1)) & 1; wr = 1; nz = 1; end
                11: begin r = (a << n) % 256; c = (n == 0) ? 0 : (a >> (8 - n)) & 1; wr = 1; nz = 1; end
                12: begin r = ((a >> n) | (a << (8 - n))) % 256;
                          c = (n == 0) ? 0 : (a >> (n - 1)) & 1; wr = 1; nz = 1; end
                default: ;
            endcase
        end
        if (nz != 0)
            m_flags = ((r >= 128) ? 8 : 0) + ov * 4 + c * 2 + ((r == 0) ? 1 : 0);
        if (wr != 0) m_res = r;
        m_we = wr;
    endtask

    task automatic compare(input string tag);
        int exp_cond;
        exp_cond = (cond_sel < 4) ? ((m_flags >> cond_sel) & 1) : ((status_in >> (cond_sel - 4)) & 1);
        checks++;
        if (result != m_res[7:0] || result_we != m_we[0] || flags != m_flags[3:0] || cond_true != exp_cond[0]) begin
            fails++;
            $display("FAIL %s: res=%02h we=%0d flags=%01h cond=%0d, expected res=%02h we=%0d flags=%01h cond=%0d",
                     tag, result, result_we, flags, cond_true, m_res[7:0], m_we, m_flags[3:0], exp_cond);
        end
    endtask

    // Inputs driven at negedge; outputs sampled at the following negedge
    task automatic step(input string tag, input int v, input int op, input int a, input int b,
                        input int n = 0, input int cs = 0, input int st = 0);
        op_valid = v[0]; op_code = op[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
        shift_amt = n[2:0]; cond_sel = cs[2:0]; status_in = st[3:0];
        @(posedge clk);
        @(negedge clk);
        model_update(v, op, a, b, n);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");

        step("R2 add overflow 7F+01", 1, 0, 8'h7F, 8'h01);
        step("R2 add carry FF+01", 1, 0, 8'hFF, 8'h01);
        step("R2 adc uses C", 1, 1, 8'h10, 8'h20);
        step("R2 add neg overflow 80+80", 1, 0, 8'h80, 8'h80);
        step("R3 sub equal", 1, 2, 8'h05, 8'h05);
        step("R3 sub borrow", 1, 2, 8'h03, 8'h05);
        step("R3 sbc uses borrow", 1, 3, 8'h10, 8'h01);
        step("R3 sub overflow 80-01", 1, 2, 8'h80, 8'h01);
        step("R4 cmp no write", 1, 4, 8'h01, 8'h02);
        step("R4 test no write", 1, 8, 8'hF0, 8'h0F);
        step("R5 and", 1, 5, 8'hF3, 8'h3C);
        step("R5 or", 1, 6, 8'h80, 8'h01);
        step("R5 xor zero", 1, 7, 8'hAA, 8'hAA);
        step("R5 not", 1, 9, 8'h00, 8'h00);
        step("R6 not to zero", 1, 9, 8'hFF, 8'h00);
        step("R7 shr n0", 1, 10, 8'h81, 0, 0);
        step("R7 shr n3", 1, 10, 8'h0C, 0, 3);
        step("R7 shl n0", 1, 11, 8'h81, 0, 0);
        step("R7 shl n1", 1, 11, 8'h81, 0, 1);
        step("R7 shl n7", 1, 11, 8'h03, 0, 7);
        step("R8 ror n0", 1, 12, 8'h01, 0, 0);
        step("R8 ror n1", 1, 12, 8'h01, 0, 1);
        step("R8 ror n7", 1, 12, 8'h81, 0, 7);
        for (int cs = 0; cs < 8; cs++) begin
            step("R9 cond select", 0, 0, 0, 0, 0, cs, 4'b1010);
            step("R9 cond select alt", 0, 0, 0, 0, 0, cs, 4'b0101);
        end
        step("R10 idle hold", 0, 0, 8'h55, 8'h55);
        step("R10 reserved code", 1, 13, 8'h00, 8'h00);
        step("R10 reserved code 15", 1, 15, 8'h12, 8'h34);
        for (int i = 0; i < 2000; i++) begin
            int op;
            op = int'($urandom_range(0, 15));
            step("R2/R3/R5/R7/R8 random stream", int'($urandom_range(0, 7) != 0), op,
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), int'($urandom_range(0, 15)));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule